// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block walks a synchronous DRAM burst one column per clock. A one-cycle start pulse captures four things: a starting column, a three-bit burst length code, a burst ordering bit and a single-write mode bit, together with a flag that marks the access as a write. From the next clock on, the block presents one column address per cycle on registered outputs. A valid flag marks each beat, and a last flag marks the final beat of a bounded burst.

Bounded bursts keep to the aligned block that contains the starting column. Only the low bits rotate, either counting up or following an XOR pattern, and the upper bits do not change. A full-row burst counts up through the whole row and wraps at the end. It stops only when a stop request arrives or a new start pulse replaces it. A stop input models a burst-stop command. A configuration that cannot be served raises an error flag, and the block then emits no beats.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After a synchronous reset, `valid_o`, `last_o` and `err_o` are low.
- R2: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give exactly 1, 2, 4 and 8 beats on consecutive clocks. `last_o` is high only on the final beat of such a burst, and `valid_o` drops on the clock after it.
- R3: With `btype_i`=0 (sequential), beat k carries the low log2(BL) bits of (start + k), and the higher column bits stay equal to those of the start column. For example, BL4 from 1 gives 1,2,3,0.
- R4: With `btype_i`=1 (interleaved), beat k carries start XOR k. For example, BL8 from 5 gives 5,4,7,6,1,0,3,2.
- R5: For length code 3'b000, one beat at the start column is produced whatever `btype_i` is.
- R6: Code 3'b111 with `btype_i`=0 is a full-row burst: beat k is (start + k) modulo 2^COL_W, it runs until stopped, and `last_o` never rises.
- R7: Code 3'b111 with `btype_i`=1, and the reserved codes 3'b100, 3'b101 and 3'b110, set `err_o` and emit no beat. `err_o` holds until the next start pulse and clears on a start with a legal setup.
- R8: When `single_wr_i` and `is_write_i` are both high at start, exactly one beat at the start column is produced for any length code, with `last_o` high. If `is_write_i` is low, `single_wr_i` has no effect.
- R9: A high `stop_i` without `start_i` makes `valid_o` low from the next clock on. When no burst is running, it has no effect.
- R10: The first beat, at the start column, appears on the clock after the start pulse. A start pulse during a running burst abandons that burst and begins the new one on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that captures the burst setup |
| start_col_i | input | COL_W | Starting column |
| blen_code_i | input | 3 | Burst length code |
| btype_i | input | 1 | 0 sequential, 1 interleaved |
| single_wr_i | input | 1 | Single-write mode bit |
| is_write_i | input | 1 | Burst is a write |
| stop_i | input | 1 | Burst-stop request |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of a bounded burst |
| err_o | output | 1 | Unsupported setup captured at last start |

## Verification
The assertions assume that the setup inputs matter only in the cycle where `start_i` is high. They also assume the beat mask cannot change while a burst runs, so the fixed-upper-bits property compares each beat only against the one before it within the same burst. The stimulus drives every input on the falling edge and holds `start_i` for one cycle. It never raises `start_i` and `stop_i` together, and it aims stop requests at beats that are actually being emitted, plus one deliberate stop while the block is idle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic [2:0] {
    BLC_1   = 3'b000,
    BLC_2   = 3'b001,
    BLC_4   = 3'b010,
    BLC_8   = 3'b011,
    BLC_ROW = 3'b111
  } blen_code_e;
endpackage

// File: rtl/colgen_cfg.sv
module colgen_cfg #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             interleave_i,
  input  logic             single_wr_i,
  input  logic             is_write_i,
  output logic [COL_W-1:0] low_mask_o,
  output logic             full_row_o,
  output logic             cfg_err_o
);
  import colgen_pkg::*;

  localparam logic [COL_W-1:0] ALL_ONES = '1;

  always_comb begin
    low_mask_o = '0;
    full_row_o = 1'b0;
    cfg_err_o  = 1'b0;
    case (blen_code_e'(code_i))
      BLC_1:   low_mask_o = COL_W'(0);
      BLC_2:   low_mask_o = COL_W'(1);
      BLC_4:   low_mask_o = COL_W'(3);
      BLC_8:   low_mask_o = COL_W'(7);
      BLC_ROW: begin
        low_mask_o = ALL_ONES;
        full_row_o = 1'b1;
        cfg_err_o  = interleave_i;
      end
      default: cfg_err_o = 1'b1;
    endcase
    // a single-write access ignores the programmed length
    if (single_wr_i && is_write_i) begin
      low_mask_o = '0;
      full_row_o = 1'b0;
      cfg_err_o  = 1'b0;
    end
  end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] low_mask_i,
  input  logic             interleave_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] xor_low;

  always_comb begin
    seq_low = (base_i + beat_i) & low_mask_i;
    xor_low = (base_i ^ beat_i) & low_mask_i;
    col_o   = (base_i & ~low_mask_i) | (interleave_i ? xor_low : seq_low);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_code_i,
  input  logic             btype_i,
  input  logic             single_wr_i,
  input  logic             is_write_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  localparam logic [COL_W-1:0] BEAT_ONE = COL_W'(1);

  logic [COL_W-1:0] cfg_mask;
  logic             cfg_full;
  logic             cfg_err;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             full_q;
  logic             run_q;
  logic [COL_W-1:0] next_col;

  colgen_cfg #(.COL_W(COL_W)) cfg_i (
    .code_i       (blen_code_i),
    .interleave_i (btype_i),
    .single_wr_i  (single_wr_i),
    .is_write_i   (is_write_i),
    .low_mask_o   (cfg_mask),
    .full_row_o   (cfg_full),
    .cfg_err_o    (cfg_err)
  );

  colgen_addr #(.COL_W(COL_W)) addr_i (
    .base_i       (base_q),
    .beat_i       (beat_q),
    .low_mask_i   (mask_q),
    .interleave_i (ilv_q),
    .col_o        (next_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      run_q   <= 1'b0;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      err_o   <= 1'b0;
    end else if (start_i) begin
      base_q <= start_col_i;
      beat_q <= BEAT_ONE;
      mask_q <= cfg_mask;
      ilv_q  <= btype_i;
      full_q <= cfg_full;
      err_o  <= cfg_err;
      if (cfg_err) begin
        run_q   <= 1'b0;
        valid_o <= 1'b0;
        last_o  <= 1'b0;
      end else begin
        col_o   <= start_col_i;
        valid_o <= 1'b1;
        last_o  <= !cfg_full && (cfg_mask == '0);
        run_q   <= cfg_full || (cfg_mask != '0);
      end
    end else if (stop_i) begin
      run_q   <= 1'b0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (run_q) begin
      col_o   <= next_col;
      valid_o <= 1'b1;
      last_o  <= !full_q && (beat_q == mask_q);
      run_q   <= full_q || (beat_q != mask_q);
      beat_q  <= beat_q + BEAT_ONE;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end

  // R2: the last flag only ever marks a real beat
  p_last_with_valid_r2: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R3: bits above the rotating field never move within a burst
  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(valid_o) && !$past(start_i))
      |-> (((col_o ^ $past(col_o)) & ~mask_q) == '0));

  // R6: a full-row burst never flags a final beat
  p_row_no_last_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && full_q) |-> !last_o);

  // R7: an unsupported setup emits nothing
  p_err_silent_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !valid_o);

  // R9: a stop request ends beat output on the next clock
  p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i) |=> !valid_o);

  // R10: a legal start puts the start column out on the next clock
  p_first_beat_r10: assert property (@(posedge clk) disable iff (rst)
    (start_i && !cfg_err) |=> (valid_o && col_o == $past(start_col_i)));
endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       blen_code_i = '0;
  logic             btype_i = 1'b0;
  logic             single_wr_i = 1'b0;
  logic             is_write_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;
  logic             err_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .blen_code_i(blen_code_i), .btype_i(btype_i), .single_wr_i(single_wr_i),
    .is_write_i(is_write_i), .stop_i(stop_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // beats in a burst: 0 = runs until stopped, -1 = unsupported
  function automatic int exp_len(input logic [2:0] code, input bit typ,
                                 input bit sw, input bit wr);
    if (sw && wr) return 1;
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return typ ? -1 : 0;
      default: return -1;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] base,
      input int k, input logic [2:0] code, input bit typ, input bit sw, input bit wr);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] kk;
    kk = COL_W'(k);
    if ((sw && wr) || code == 3'b000) return base;
    if (code == 3'b111) return base + kk;
    m = COL_W'((1 << code) - 1);
    if (typ) return base ^ kk;
    return (base & ~m) | ((base + kk) & m);
  endfunction

  task automatic drive_start(input logic [COL_W-1:0] c, input logic [2:0] code,
                             input bit typ, input bit sw, input bit wr);
    start_i = 1'b1; start_col_i = c; blen_code_i = code;
    btype_i = typ; single_wr_i = sw; is_write_i = wr;
  endtask

  // starts a burst, follows every beat and an optional stop request
  task automatic do_burst(input logic [COL_W-1:0] c, input logic [2:0] code,
                          input bit typ, input bit sw, input bit wr, input int stop_after);
    int len;
    int n;
    bit stopping;
    string tag;
    len = exp_len(code, typ, sw, wr);
    @(negedge clk);
    drive_start(c, code, typ, sw, wr);
    @(negedge clk);
    start_i = 1'b0;
    if (len < 0) begin
      chk(err_o == 1'b1, "R7", "err_o", int'(err_o), 1);
      chk(valid_o == 1'b0, "R7", "valid_o", int'(valid_o), 0);
      @(negedge clk);
      chk(valid_o == 1'b0 && err_o == 1'b1, "R7", "held valid/err", int'({err_o, valid_o}), 2);
      return;
    end
    chk(err_o == 1'b0, "R7", "err_o clear", int'(err_o), 0);
    if (sw && wr)           tag = "R8";
    else if (code == 3'b111) tag = "R6";
    else if (code == 3'b000) tag = "R5";
    else if (typ)            tag = "R4";
    else                     tag = "R3";
    if (len == 0) n = (stop_after > 0) ? stop_after : 16;
    else          n = (stop_after > 0 && stop_after < len) ? stop_after : len;
    stopping = (len == 0) || (n < len);
    for (int k = 0; k < n; k++) begin
      chk(valid_o == 1'b1, "R2", "valid_o", int'(valid_o), 1);
      chk(col_o == exp_col(c, k, code, typ, sw, wr), tag, "col_o",
          int'(col_o), int'(exp_col(c, k, code, typ, sw, wr)));
      chk(last_o == (len > 0 && k == len - 1), (len == 0) ? "R6" : "R2", "last_o",
          int'(last_o), int'(len > 0 && k == len - 1));
      if (stopping && k == n - 1) stop_i = 1'b1;
      if (k < n - 1) @(negedge clk);
    end
    @(negedge clk);
    stop_i = 1'b0;
    chk(valid_o == 1'b0, stopping ? "R9" : "R2", "valid_o after end", int'(valid_o), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [2:0] codes [6];
    codes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111, 3'b101};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0 && last_o == 1'b0 && err_o == 1'b0, "R1", "reset outputs",
        int'({valid_o, last_o, err_o}), 0);

    do_burst(8'h41, 3'b010, 1'b0, 1'b0, 1'b0, 0);   // R3 1-2-3-0 in block
    do_burst(8'h05, 3'b011, 1'b1, 1'b0, 1'b0, 0);   // R4 5-4-7-6-1-0-3-2
    do_burst(8'h37, 3'b000, 1'b1, 1'b0, 1'b0, 0);   // R5 type ignored
    do_burst(8'h03, 3'b001, 1'b0, 1'b0, 1'b0, 0);   // R2 two beats
    do_burst(8'hFC, 3'b111, 1'b0, 1'b0, 1'b0, 8);   // R6 wrap over row end
    do_burst(8'h10, 3'b111, 1'b0, 1'b0, 1'b0, 300); // R6 longer than a row
    do_burst(8'h20, 3'b111, 1'b1, 1'b0, 1'b0, 0);   // R7 interleaved full row
    do_burst(8'h20, 3'b100, 1'b0, 1'b0, 1'b0, 0);   // R7 reserved code
    do_burst(8'h66, 3'b011, 1'b0, 1'b1, 1'b1, 0);   // R8 single write
    do_burst(8'h66, 3'b010, 1'b1, 1'b1, 1'b0, 0);   // R8 read ignores mode bit
    do_burst(8'h88, 3'b011, 1'b0, 1'b0, 1'b0, 3);   // R9 early stop

    // R9: stop while idle leaves the outputs quiet
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk(valid_o == 1'b0 && last_o == 1'b0, "R9", "idle stop", int'({valid_o, last_o}), 0);

    // R10: restart during a running burst
    @(negedge clk); drive_start(8'h10, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk); start_i = 1'b0;
    chk(valid_o && col_o == 8'h10, "R10", "first beat", int'(col_o), 16);
    @(negedge clk);
    chk(col_o == 8'h11, "R10", "second beat", int'(col_o), 17);
    drive_start(8'h25, 3'b010, 1'b1, 1'b0, 1'b0);
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(valid_o == 1'b1 && col_o == (8'h25 ^ 8'(k)), "R10", "restart col",
          int'(col_o), int'(8'h25 ^ 8'(k)));
      chk(last_o == (k == 3), "R10", "restart last", int'(last_o), int'(k == 3));
      @(negedge clk);
    end
    chk(valid_o == 1'b0, "R10", "restart end", int'(valid_o), 0);

    for (int i = 0; i < 60; i++) begin
      logic [2:0] code;
      int sa;
      code = codes[$urandom_range(5, 0)];
      sa = ($urandom_range(3, 0) == 0) ? int'($urandom_range(9, 1)) : 0;
      if (code == 3'b111) sa = int'($urandom_range(300, 1));
      do_burst(8'($urandom), code, 1'($urandom), 1'($urandom), 1'($urandom), sa);
    end
    finish_run();
  end
endmodule